// File: doc/BRIEF.md
# Word-Serial Block Cipher I/O Sequencer

This block moves 128-bit text blocks into and out of an iterative cipher engine over a 32-bit word interface. Software or an upstream stage writes the three lower words of a block into staging storage, in any order and at any time. Writing the top word, together with the encrypt/decrypt choice, launches the block into the engine. The three lower words are addressed 0 to 2 and the top word is address 3.

A status output tells the writer when a top word will be taken. The lower words of the next block can be written while the current block is still being processed, so loading overlaps computation. A new block can be launched in the very cycle the engine finishes, which gives one block per engine latency with no dead cycles.

Each result comes back as a burst of four words on consecutive cycles, lowest word first, with a valid strobe and a word address. The round datapath is represented by a stand-in engine with a start/done handshake and a fixed, parameterised latency: 44 cycles for a compact build and 11 for a fast one. The stand-in applies a simple reversible transform.

Top module: `aes_wordio_ctrl`

## Requirements
- R1: A block is formed from four 32-bit words written with `in_load` high and `in_addr` giving the word index. Index 0 is bits 31:0 of the block and index 3 is bits 127:96.
- R2: In the clock cycle after a top word (index 3) is accepted, `in_ready` is low.
- R3: `in_ready` is high while no block is in flight. After a block is accepted at a clock edge, `in_ready` stays low for the next LATENCY-1 cycles and is high in the LATENCY-th cycle. A top word written in a cycle where `in_ready` is high is accepted.
- R4: Words at indices 0 to 2 are stored whenever written, including while a block is in flight. They keep their values until overwritten, including across later blocks. Writing them never alters the result of the block in flight.
- R5: Result word 0 appears in cycle LATENCY+1 after the accepting edge, and words 1, 2 and 3 follow in the next three cycles. Each word has `out_valid` high and `out_addr` equal to its index. `out_valid` is low in every cycle outside such a burst.
- R6: A top word accepted in the cycle where `in_ready` has just returned high starts the next block with no gap. Its burst starts LATENCY cycles after the previous burst and never interleaves with it.
- R7: `in_mode` = 0 selects encryption and 1 selects decryption. The stand-in engine returns block XOR TWEAK for encryption and the bitwise inverse of the block for decryption.
- R8: The mode is sampled with the top word. Changes to `in_mode` afterwards do not affect the block in flight.
- R9: A top-word write while `in_ready` is low is ignored. It produces no extra result burst and does not change the block in flight.
- R10: `rst_n` is an asynchronous active-low reset. While it is low and after it is released, `in_ready` is high and `out_valid` is low, and any block in flight is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_load | input | 1 | Text word write strobe |
| in_addr | input | 2 | Text word index, 0 = least significant |
| in_data | input | 32 | Text word |
| in_mode | input | 1 | 0 encrypt, 1 decrypt; sampled with the top word |
| in_ready | output | 1 | High when a top word will be accepted |
| out_valid | output | 1 | Result word strobe |
| out_addr | output | 2 | Result word index, 0 = least significant |
| out_data | output | 32 | Result word |

## Verification
The bench writes the lower words of a second block while the first is in flight, then fires the second top word in the exact cycle `in_ready` rises. A design that let staging writes leak into the running block would return a corrupted first result. A design with an off-by-one ready window would either drop the second top word or start it a cycle late.

The bench also writes a stray top word while the engine is busy. A design that honoured it would emit a fifth burst or change the running result. It toggles the mode after launch, which catches a design that reads the mode live instead of latching it. It fires a top word with no fresh lower words, which exposes a design that clears staging after use. Finally, it resets mid-block, which catches a design that emits the abandoned result.

// File: rtl/aes_wordio_pkg.sv
package aes_wordio_pkg;

    typedef enum logic {
        CIPHER_ENC = 1'b0,
        CIPHER_DEC = 1'b1
    } cipher_dir_e;

    // Smallest latency that keeps one result burst clear of the next.
    localparam int MIN_LATENCY = 4;

endpackage

// File: rtl/wio_in_stage.sv
module wio_in_stage
    import aes_wordio_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    localparam int ADDR_W   = $clog2(NUM_WORDS),
    localparam int TOP_IDX  = NUM_WORDS - 1,
    localparam int LOW_W    = WORD_W * TOP_IDX,
    localparam int BLOCK_W  = WORD_W * NUM_WORDS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [WORD_W-1:0]   data_i,
    input  logic                mode_i,
    input  logic                engine_free_i,
    output logic                start_o,
    output logic [BLOCK_W-1:0]  start_text_o,
    output cipher_dir_e         start_mode_o
);

    typedef struct packed {
        logic [LOW_W-1:0] low;
    } stage_t;

    stage_t stage_q, stage_d;
    logic   top_write;

    always_comb begin
        stage_d   = stage_q;
        top_write = load_i && (addr_i == ADDR_W'(TOP_IDX));
        for (int i = 0; i < TOP_IDX; i++) begin
            if (load_i && (addr_i == ADDR_W'(i))) begin
                stage_d.low[i*WORD_W +: WORD_W] = data_i;
            end
        end
        start_o      = top_write && engine_free_i;
        start_text_o = {data_i, stage_q.low};
        start_mode_o = cipher_dir_e'(mode_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    // R4: staged words change only when a write strobe is present.
    assert_low_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(stage_q.low));

endmodule

// File: rtl/wio_engine_model.sv
module wio_engine_model
    import aes_wordio_pkg::*;
#(
    parameter int                 BLOCK_W = 128,
    parameter int                 LATENCY = 44,
    parameter logic [BLOCK_W-1:0] TWEAK   = '0,
    localparam int EFF_LAT = (LATENCY < MIN_LATENCY) ? MIN_LATENCY : LATENCY,
    localparam int CNT_W   = $clog2(EFF_LAT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [BLOCK_W-1:0] text_i,
    input  cipher_dir_e        mode_i,
    output logic               free_o,
    output logic               done_o,
    output logic [BLOCK_W-1:0] result_o
);

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [BLOCK_W-1:0] text;
        cipher_dir_e        mode;
    } eng_t;

    eng_t eng_q, eng_d;

    always_comb begin
        eng_d  = eng_q;
        done_o = eng_q.busy && (eng_q.cnt == CNT_W'(1));
        free_o = !eng_q.busy || done_o;
        if (start_i) begin
            eng_d.busy = 1'b1;
            eng_d.cnt  = CNT_W'(EFF_LAT);
            eng_d.text = text_i;
            eng_d.mode = mode_i;
        end else if (done_o) begin
            eng_d.busy = 1'b0;
            eng_d.cnt  = '0;
        end else if (eng_q.busy) begin
            eng_d.cnt = eng_q.cnt - CNT_W'(1);
        end
        result_o = (eng_q.mode == CIPHER_DEC) ? ~eng_q.text : (eng_q.text ^ TWEAK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    // R9: the input stage only launches a job when this engine can take it.
    assert_single_job_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (!eng_q.busy || done_o));

    // R8: the latched mode holds while a job runs and nothing new starts.
    assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.busy && !done_o && !start_i) |=> $stable(eng_q.mode));

endmodule

// File: rtl/wio_out_serializer.sv
module wio_out_serializer #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    localparam int ADDR_W   = $clog2(NUM_WORDS),
    localparam int BLOCK_W  = WORD_W * NUM_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [BLOCK_W-1:0] block_i,
    output logic               valid_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [WORD_W-1:0]  data_o
);

    typedef struct packed {
        logic               active;
        logic [ADDR_W-1:0]  idx;
        logic [BLOCK_W-1:0] held;
    } ser_t;

    ser_t ser_q, ser_d;
    logic last_word;

    always_comb begin
        ser_d     = ser_q;
        last_word = ser_q.idx == ADDR_W'(NUM_WORDS - 1);
        if (ser_q.active) begin
            if (last_word) begin
                ser_d.active = 1'b0;
            end else begin
                ser_d.idx = ser_q.idx + ADDR_W'(1);
            end
        end
        if (load_i) begin
            ser_d.active = 1'b1;
            ser_d.idx    = '0;
            ser_d.held   = block_i;
        end
        valid_o = ser_q.active;
        addr_o  = ser_q.idx;
        data_o  = ser_q.held[ser_q.idx*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= '0;
        end else begin
            ser_q <= ser_d;
        end
    end

    // R6: a new result arrives only when the previous burst is done or on its last word.
    assert_no_interleave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!ser_q.active || last_word));

endmodule

// File: rtl/aes_wordio_ctrl.sv
module aes_wordio_ctrl
    import aes_wordio_pkg::*;
#(
    parameter int                   WORD_W    = 32,
    parameter int                   NUM_WORDS = 4,
    parameter int                   LATENCY   = 44,
    parameter logic [WORD_W*NUM_WORDS-1:0] TWEAK =
        128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0,
    localparam int ADDR_W  = $clog2(NUM_WORDS),
    localparam int BLOCK_W = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_mode,
    output logic              in_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [WORD_W-1:0] out_data
);

    logic               start;
    logic [BLOCK_W-1:0] start_text;
    cipher_dir_e        start_mode;
    logic               eng_free;
    logic               eng_done;
    logic [BLOCK_W-1:0] eng_result;

    wio_in_stage #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_in_stage (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (in_load),
        .addr_i        (in_addr),
        .data_i        (in_data),
        .mode_i        (in_mode),
        .engine_free_i (eng_free),
        .start_o       (start),
        .start_text_o  (start_text),
        .start_mode_o  (start_mode)
    );

    wio_engine_model #(
        .BLOCK_W (BLOCK_W),
        .LATENCY (LATENCY),
        .TWEAK   (TWEAK)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .text_i   (start_text),
        .mode_i   (start_mode),
        .free_o   (eng_free),
        .done_o   (eng_done),
        .result_o (eng_result)
    );

    wio_out_serializer #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_out_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (eng_done),
        .block_i (eng_result),
        .valid_o (out_valid),
        .addr_o  (out_addr),
        .data_o  (out_data)
    );

    assign in_ready = eng_free;

    // R2: status drops in the cycle after a top word is taken.
    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_load && in_addr == ADDR_W'(NUM_WORDS - 1) && in_ready) |=> !in_ready);

    // R5: every burst opens with the lowest word.
    assert_first_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_addr == '0);

    // R5: words of a burst occupy consecutive cycles in rising address order.
    assert_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_addr != ADDR_W'(NUM_WORDS - 1)) |=>
            (out_valid && out_addr == $past(out_addr) + ADDR_W'(1)));

endmodule

// File: tb/aes_wordio_ctrl_bench.sv
module aes_wordio_ctrl_bench;

    localparam int LAT = 44;
    localparam logic [127:0] TWEAK = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

    // Stimulus table: {mode, block}
    localparam logic [128:0] VECS [6] = '{
        {1'b0, 128'h00112233_44556677_8899AABB_CCDDEEFF},
        {1'b1, 128'h00112233_44556677_8899AABB_CCDDEEFF},
        {1'b0, 128'h00000000_00000000_00000000_00000000},
        {1'b1, 128'hFFFFFFFF_00000000_FFFFFFFF_00000000},
        {1'b0, 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D},
        {1'b1, 128'h13579BDF_2468ACE0_0F0F0F0F_F0F0F0F0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_load = 1'b0;
    logic [1:0]  in_addr = '0;
    logic [31:0] in_data = '0;
    logic        in_mode = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [1:0]  out_addr;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    aes_wordio_ctrl u_aes_wordio_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_load   (in_load),
        .in_addr   (in_addr),
        .in_data   (in_data),
        .in_mode   (in_mode),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] model(input logic m, input logic [127:0] t);
        return m ? ~t : (t ^ TWEAK);
    endfunction

    task automatic put(input logic ld, input logic [1:0] a,
                       input logic [31:0] d, input logic m);
        in_load = ld;
        in_addr = a;
        in_data = d;
        in_mode = m;
    endtask

    task automatic write_lows(input logic [127:0] t, input logic m);
        for (int w = 0; w < 3; w++) begin
            put(1'b1, 2'(w), t[w*32 +: 32], m);
            @(negedge clk);
        end
    endtask

    // One block; optional lower-word skip, mode toggle, stray top write.
    task automatic run_single(input logic m, input logic [127:0] t, input bit skip_lows,
                              input bit chg_mode, input bit stray_top, input string tag);
        logic [127:0] exp;
        bit rdy_ok;
        exp = model(m, t);
        rdy_ok = 1'b1;
        if (!skip_lows) write_lows(t, m);
        check(in_ready == 1'b1, {tag, " R3 idle ready"}, 128'(in_ready), 128'd1);
        put(1'b1, 2'd3, t[127:96], m);
        @(negedge clk);
        put(1'b0, 2'd0, 32'd0, m);
        for (int j = 1; j <= LAT + 5; j++) begin
            if (j < LAT && in_ready) rdy_ok = 1'b0;
            if (j == LAT && !in_ready) rdy_ok = 1'b0;
            if (j == 1) check(!in_ready, {tag, " R2 ready low"}, 128'(in_ready), 128'd0);
            if (j >= LAT + 1 && j <= LAT + 4) begin
                int k;
                k = j - LAT - 1;
                check(out_valid && out_addr == 2'(k) && out_data == exp[k*32 +: 32],
                      {tag, " R5 R7 word"}, {out_valid, 29'd0, out_addr, 32'd0, out_data},
                      {1'b1, 29'd0, 2'(k), 32'd0, exp[k*32 +: 32]});
            end
            if (j == LAT + 5) check(!out_valid, {tag, " R5 burst end"}, 128'(out_valid), 128'd0);
            if (chg_mode && j == 1) put(1'b0, 2'd0, 32'd0, ~m);
            if (stray_top && j == 3) put(1'b1, 2'd3, ~t[127:96], ~m);
            else if (stray_top && j == 4) put(1'b0, 2'd0, 32'd0, m);
            @(negedge clk);
        end
        put(1'b0, 2'd0, 32'd0, 1'b0);
        check(rdy_ok, {tag, " R3 ready window"}, 128'(rdy_ok), 128'd1);
    endtask

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R5 actual=timeout expected=completion");
        summary_and_end();
    end

    initial begin
        logic [127:0] a_blk;
        logic [127:0] b_blk;
        logic [127:0] a_exp;
        logic [127:0] b_exp;
        logic [127:0] ret_blk;
        bit b2b_rdy;
        int stray_cnt;

        // R10: reset state
        @(negedge clk);
        @(negedge clk);
        check(in_ready && !out_valid, "R10 during reset", {in_ready, out_valid}, 128'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid, "R10 after reset", {in_ready, out_valid}, 128'b10);

        // R1 R5 R7: table walk
        for (int v = 0; v < 6; v++) begin
            run_single(VECS[v][128], VECS[v][127:0], 1'b0, 1'b0, 1'b0, "R1 table");
        end

        // R8: mode toggled after launch
        run_single(1'b0, 128'hA5A5A5A5_5A5A5A5A_01020304_F0E0D0C0, 1'b0, 1'b1, 1'b0, "R8 mode latch");

        // R9: stray top write while busy
        a_blk = 128'h11111111_22222222_33333333_44444444;
        run_single(1'b1, a_blk, 1'b0, 1'b0, 1'b1, "R9 stray top");
        stray_cnt = 0;
        for (int j = 0; j < 3 * LAT; j++) begin
            if (out_valid) stray_cnt++;
            @(negedge clk);
        end
        check(stray_cnt == 0, "R9 no extra burst", 128'(stray_cnt), 128'd0);

        // R4: staged lower words persist across blocks
        ret_blk = {32'h77778888, a_blk[95:0]};
        run_single(1'b0, ret_blk, 1'b1, 1'b0, 1'b0, "R4 staged retain");

        // R4 R6: back-to-back with overlapped lower-word writes
        a_blk = 128'hCAFEBABE_0BADF00D_FEEDFACE_12345678;
        b_blk = 128'h9ABCDEF0_0FEDCBA9_55AA55AA_AA55AA55;
        a_exp = model(1'b0, a_blk);
        b_exp = model(1'b1, b_blk);
        b2b_rdy = 1'b1;
        write_lows(a_blk, 1'b0);
        put(1'b1, 2'd3, a_blk[127:96], 1'b0);
        @(negedge clk);
        put(1'b0, 2'd0, 32'd0, 1'b0);
        for (int j = 1; j <= 2 * LAT + 5; j++) begin
            if (j == 1) check(!in_ready, "R2 b2b first", 128'(in_ready), 128'd0);
            if ((j < LAT) && in_ready) b2b_rdy = 1'b0;
            if (j == LAT) check(in_ready, "R3 b2b ready rise", 128'(in_ready), 128'd1);
            if (j == LAT + 1) check(!in_ready, "R6 b2b second accepted", 128'(in_ready), 128'd0);
            if (j > LAT + 1 && j < 2 * LAT && in_ready) b2b_rdy = 1'b0;
            if (j == 2 * LAT) check(in_ready, "R6 b2b second done", 128'(in_ready), 128'd1);
            if (j >= LAT + 1 && j <= LAT + 4) begin
                int k;
                k = j - LAT - 1;
                check(out_valid && out_addr == 2'(k) && out_data == a_exp[k*32 +: 32],
                      "R4 first block undisturbed", {out_valid, 29'd0, out_addr, 32'd0, out_data},
                      {1'b1, 29'd0, 2'(k), 32'd0, a_exp[k*32 +: 32]});
            end
            if (j == LAT + 5 || j == 2 * LAT) check(!out_valid, "R6 gap between bursts", 128'(out_valid), 128'd0);
            if (j >= 2 * LAT + 1 && j <= 2 * LAT + 4) begin
                int k;
                k = j - 2 * LAT - 1;
                check(out_valid && out_addr == 2'(k) && out_data == b_exp[k*32 +: 32],
                      "R6 second block", {out_valid, 29'd0, out_addr, 32'd0, out_data},
                      {1'b1, 29'd0, 2'(k), 32'd0, b_exp[k*32 +: 32]});
            end
            if (j == 2 * LAT + 5) check(!out_valid, "R5 b2b end", 128'(out_valid), 128'd0);
            // stimulus for the following edge
            if (j >= 2 && j <= 4) put(1'b1, 2'(j - 2), b_blk[(j-2)*32 +: 32], 1'b0);
            else if (j == LAT) put(1'b1, 2'd3, b_blk[127:96], 1'b1);
            else put(1'b0, 2'd0, 32'd0, 1'b0);
            @(negedge clk);
        end
        check(b2b_rdy, "R3 b2b ready windows", 128'(b2b_rdy), 128'd1);

        // R10: reset while a block is in flight
        write_lows(a_blk, 1'b0);
        put(1'b1, 2'd3, a_blk[127:96], 1'b0);
        @(negedge clk);
        put(1'b0, 2'd0, 32'd0, 1'b0);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(in_ready && !out_valid, "R10 mid-block reset", {in_ready, out_valid}, 128'b10);
        rst_n = 1'b1;
        stray_cnt = 0;
        for (int j = 0; j < LAT + 8; j++) begin
            if (out_valid || !in_ready) stray_cnt++;
            @(negedge clk);
        end
        check(stray_cnt == 0, "R10 abandoned block silent", 128'(stray_cnt), 128'd0);

        summary_and_end();
    end

endmodule